// File: doc/BRIEF.md
# DRAM Read Prefetch FIFO Controller

This block connects a host register port to a word-wide DRAM command port for host-mode transfers. Host reads are served from a prefetch FIFO. When a read request finds that FIFO empty, the controller fetches a whole burst of consecutive words from DRAM, starting at the current address. Later reads pop the buffered words without touching DRAM. Host writes go straight to DRAM, one word per request. The current address advances by one for every completed DRAM word, whether read or written.

A flush command discards any buffered words. The host must flush before it writes or leaves read mode. A write that arrives while buffered words exist, or while a fill is running, is refused and does not reach DRAM. The refusal raises a sticky error flag. Two status bits, one for reads and one for writes, show whether a DRAM operation is in flight. Loads of the address and mode registers take effect only when both bits are high.

The DRAM port carries one command at a time. `mem_req` is held, together with its address, direction and write data, until the memory returns a one-cycle `mem_ack`. On a read, `mem_ack` also carries the data.

Top module: `dram_prefetch_ctrl`

## Requirements
- R1: After reset: `rd_ready`=1, `wr_ready`=1, `wr_err`=0, `cur_addr`=0, `cur_mode`=0, `mem_req`=0 and `host_rd_valid`=0. The FIFO is empty.
- R2: In host mode (mode code 0), a read request that finds the FIFO empty starts a fill. The fill issues exactly 16 DRAM reads (`mem_we`=0) at `cur_addr`, `cur_addr`+1, … `cur_addr`+15, then stops. Afterwards `cur_addr` has advanced by 16.
- R3: `rd_ready` is 0 from the cycle after a fill starts until the cycle after its 16th `mem_ack`. `wr_ready` is 0 from the cycle after a write is accepted until the cycle after its `mem_ack`.
- R4: Each read request produces one `host_rd_valid` pulse. The words come out in DRAM address order. A request that finds the FIFO empty waits until the first fetched word arrives and is then answered.
- R5: A read request that finds the FIFO non-empty is answered from the FIFO and issues no DRAM command.
- R6: A write is accepted when all of these hold: the block is idle, the FIFO is empty, and no read is requested or waiting. An accepted write issues one DRAM write (`mem_we`=1) of `host_wr_data` at `cur_addr`. `cur_addr` then advances by 1.
- R7: Any other write request is refused. This includes a write while the FIFO is non-empty (judged before a same-cycle flush), during a fill, during an outstanding write, or in the same cycle as a read request. A refused write issues no DRAM write and sets `wr_err`. `wr_err` stays 1 until reset.
- R8: A flush outside a fill empties the FIFO, so the next read starts a new fill. A read request in the same cycle as such a flush starts a fill. A flush during a fill is ignored, and the buffered sequence continues unbroken.
- R9: `host_addr_ld` and `host_mode_ld` are ignored unless `rd_ready` and `wr_ready` are both 1. When accepted, the new value shows on `cur_addr`/`cur_mode` in the next cycle, and the next fill or write uses it.
- R10: When `cur_mode` is not 0, host read and write requests are ignored. They cause no DRAM command, no `host_rd_valid` and no `wr_err`.
- R11: A read request that arrives while a write is outstanding is held. Its fill starts once the write is acknowledged, at the advanced address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_rd_req | input | 1 | One-cycle read (pop) request |
| host_rd_valid | output | 1 | One-cycle pulse, read word available |
| host_rd_data | output | DW | Read word |
| host_wr_req | input | 1 | One-cycle write request |
| host_wr_data | input | DW | Write word |
| host_flush | input | 1 | Discard buffered words |
| host_addr_ld | input | 1 | Load DRAM address |
| host_addr | input | AW | Address to load |
| host_mode_ld | input | 1 | Load transfer mode |
| host_mode | input | MW | Mode to load (0 = host mode) |
| rd_ready | output | 1 | No fill in progress |
| wr_ready | output | 1 | No write outstanding |
| wr_err | output | 1 | Sticky refused-write flag |
| cur_addr | output | AW | Current DRAM address |
| cur_mode | output | MW | Current transfer mode |
| mem_req | output | 1 | DRAM command valid, held until ack |
| mem_we | output | 1 | DRAM command is a write |
| mem_addr | output | AW | DRAM word address |
| mem_wdata | output | DW | DRAM write data |
| mem_ack | input | 1 | DRAM command done (read data valid) |
| mem_rdata | input | DW | DRAM read data |

## Verification
Two collisions need directed stimulus.

The first is a FIFO pop landing in the same cycle as a fill push. The bench starts a fill with immediate acknowledges, then issues a new pop as soon as each word returns. Pushes and pops therefore interleave during the burst. The result is judged by the popped words following the address order exactly, by exactly 16 DRAM reads, and by the 17th read starting a new burst at the base address plus 16.

The second is a write request in the same cycle as a read request on an empty FIFO. It is judged by the write being refused (`wr_err` set, no DRAM write) while the read's fill proceeds from the unchanged address.

// File: rtl/pf_pkg.sv
// Package: shared types and codes for the prefetch DRAM controller.
// Assumes: nothing beyond IEEE 1800-2017.
package pf_pkg;

    // Sequencer states of the DRAM command side.
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_FILL  = 2'd1,
        SQ_WRITE = 2'd2
    } seq_state_t;

    // Transfer-mode code under which host reads and writes are served.
    localparam logic [1:0] MODE_HOST = 2'd0;

endpackage

// File: rtl/pf_fifo.sv
// Module: pf_fifo
// A circular word buffer with a synchronous clear, holding prefetched DRAM words.
// Assumes: the caller never pushes when full, never pops when empty, and
// never asserts clr together with push or pop.
module pf_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    input  logic          clr,
    output logic [DW-1:0] rdata,
    output logic          empty,
    output logic          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam bit POW2 = (DEPTH == (1 << PW));

    logic [DW-1:0] store [DEPTH];
    logic [PW-1:0] wptr_q, rptr_q, wptr_nx, rptr_nx;
    logic [CW-1:0] cnt_q;

    // Pointer advance: natural wrap for power-of-two depths, compare otherwise.
    generate
        if (POW2) begin : g_wrap_pow2
            assign wptr_nx = wptr_q + PW'(1);
            assign rptr_nx = rptr_q + PW'(1);
        end else begin : g_wrap_cmp
            assign wptr_nx = (wptr_q == PW'(DEPTH - 1)) ? '0 : wptr_q + PW'(1);
            assign rptr_nx = (rptr_q == PW'(DEPTH - 1)) ? '0 : rptr_q + PW'(1);
        end
    endgenerate

    // Track pointers and occupancy; clear empties the buffer at once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else if (clr) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) wptr_q <= wptr_nx;
            if (pop)  rptr_q <= rptr_nx;
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    // Store incoming words; storage itself needs no reset.
    always_ff @(posedge clk) begin
        if (push) store[wptr_q] <= wdata;
    end

    assign rdata = store[rptr_q];
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CW'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);  // R2
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);  // R4
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty);  // R8

endmodule

// File: rtl/pf_regs.sv
// Module: pf_regs
// Holds the current DRAM address and transfer mode. The address advances on
// every completed DRAM word. Loads are honoured only while both ready bits are high.
// Assumes: step is never high while both ready bits are high.
module pf_regs #(
    parameter int AW = 20,
    parameter int MW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_ld,
    input  logic [AW-1:0] addr_in,
    input  logic          mode_ld,
    input  logic [MW-1:0] mode_in,
    input  logic          both_ready,
    input  logic          step,
    output logic [AW-1:0] cur_addr,
    output logic [MW-1:0] cur_mode
);
    logic [AW-1:0] addr_q;
    logic [MW-1:0] mode_q;

    // Address register: gated load, otherwise post-increment per DRAM word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (addr_ld && both_ready) begin
            addr_q <= addr_in;
        end else if (step) begin
            addr_q <= addr_q + AW'(1);
        end
    end

    // Mode register: gated load only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (mode_ld && both_ready) begin
            mode_q <= mode_in;
        end
    end

    assign cur_addr = addr_q;
    assign cur_mode = mode_q;

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!both_ready && !step) |=> $stable(cur_addr));  // R9
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !both_ready |=> $stable(cur_mode));  // R9

endmodule

// File: rtl/pf_rdport.sv
// Module: pf_rdport
// Host read side. It answers pop requests from the FIFO and holds one request
// that found the FIFO empty, asking the sequencer for a fill.
// Assumes: a same-cycle flush makes the FIFO count as empty for this cycle.
module pf_rdport #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic          flush_act,
    input  logic          fifo_empty,
    input  logic [DW-1:0] fifo_rdata,
    output logic          pop,
    output logic          fill_need,
    output logic          pend,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    logic          pend_q;
    logic          valid_q;
    logic [DW-1:0] data_q;
    logic          serve;
    logic          eff_empty;

    // Decide whether a live request pops now or must wait for a fill.
    always_comb begin
        serve     = pend_q || rd_req;
        eff_empty = fifo_empty || flush_act;
        pop       = serve && !eff_empty;
        fill_need = serve && eff_empty;
    end

    // Hold a request that could not be served from the FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (pop) begin
            pend_q <= 1'b0;
        end else if (rd_req) begin
            pend_q <= 1'b1;
        end
    end

    // Register the popped word and its valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= pop;
            if (pop) data_q <= fifo_rdata;
        end
    end

    assign pend     = pend_q;
    assign rd_valid = valid_q;
    assign rd_data  = data_q;

    AST_PEND_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !fifo_empty && !flush_act) |=> rd_valid);  // R4

endmodule

// File: rtl/pf_seq.sv
// Module: pf_seq
// DRAM command sequencer. It runs 16-word fills and single-word writes, one
// command outstanding at a time, and judges every host write as accepted or refused.
// Assumes: mem_ack arrives only while mem_req is high.
module pf_seq #(
    parameter int DW    = 32,
    parameter int AW    = 20,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_data,
    input  logic          fill_need,
    input  logic          fifo_empty,
    input  logic          mem_ack,
    input  logic [AW-1:0] mem_addr,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    output logic          push,
    output logic          step,
    output logic          rd_ready,
    output logic          wr_ready,
    output logic          wr_err
);
    import pf_pkg::*;

    localparam int FCW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    seq_state_t    state_q, state_nx;
    logic [FCW-1:0] fcnt_q;
    logic [DW-1:0] wdata_q;
    logic          err_q;
    logic          last_word;
    logic          wr_accept;

    // Write acceptance: idle, empty FIFO, and no read live or waiting.
    always_comb begin
        wr_accept = wr_req && (state_q == SQ_IDLE) && fifo_empty && !fill_need;
        last_word = (fcnt_q == FCW'(DEPTH - 1));
    end

    // Next-state choice; a waiting read wins over a write.
    always_comb begin
        state_nx = state_q;
        case (state_q)
            SQ_IDLE: begin
                if (fill_need)      state_nx = SQ_FILL;
                else if (wr_accept) state_nx = SQ_WRITE;
            end
            SQ_FILL: begin
                if (mem_ack && last_word) state_nx = SQ_IDLE;
            end
            SQ_WRITE: begin
                if (mem_ack) state_nx = fill_need ? SQ_FILL : SQ_IDLE;
            end
            default: state_nx = SQ_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_nx;
    end

    // Burst word counter: cleared on entry, bumped per fetched word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcnt_q <= '0;
        end else if (state_q != SQ_FILL) begin
            fcnt_q <= '0;
        end else if (mem_ack) begin
            fcnt_q <= fcnt_q + FCW'(1);
        end
    end

    // Capture write data at acceptance so it stays stable while requested.
    always_ff @(posedge clk) begin
        if (!rst_n)         wdata_q <= '0;
        else if (wr_accept) wdata_q <= wr_data;
    end

    // Sticky refusal flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                    err_q <= 1'b0;
        else if (wr_req && !wr_accept) err_q <= 1'b1;
    end

    assign mem_req   = (state_q != SQ_IDLE);
    assign mem_we    = (state_q == SQ_WRITE);
    assign mem_wdata = wdata_q;
    assign push      = (state_q == SQ_FILL) && mem_ack;
    assign step      = mem_ack;
    assign rd_ready  = (state_q != SQ_FILL);
    assign wr_ready  = (state_q != SQ_WRITE);
    assign wr_err    = err_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));  // R2
    AST_FILL_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !last_word) |=> (mem_addr == $past(mem_addr) + AW'(1)));  // R2
    AST_WE_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> fifo_empty);  // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> wr_err);  // R7
    AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!rd_ready, !wr_ready}));  // R3

endmodule

// File: rtl/dram_prefetch_ctrl.sv
// Module: dram_prefetch_ctrl (top)
// Host-mode DRAM access with a 16-word read prefetch FIFO, flush, gated
// address and mode loads, and refusal of writes while data is buffered.
// Assumes: the DRAM side acknowledges each held request exactly once.
module dram_prefetch_ctrl #(
    parameter int DW    = 32,
    parameter int AW    = 20,
    parameter int MW    = 2,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_rd_req,
    output logic          host_rd_valid,
    output logic [DW-1:0] host_rd_data,
    input  logic          host_wr_req,
    input  logic [DW-1:0] host_wr_data,
    input  logic          host_flush,
    input  logic          host_addr_ld,
    input  logic [AW-1:0] host_addr,
    input  logic          host_mode_ld,
    input  logic [MW-1:0] host_mode,
    output logic          rd_ready,
    output logic          wr_ready,
    output logic          wr_err,
    output logic [AW-1:0] cur_addr,
    output logic [MW-1:0] cur_mode,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata
);
    import pf_pkg::*;

    logic          in_host;
    logic          rd_req_h, wr_req_h, flush_act;
    logic          pop, push, fill_need, pend, step;
    logic          fifo_empty, fifo_full;
    logic [DW-1:0] fifo_rdata;

    // Qualify host requests by mode; a flush acts only outside a fill.
    always_comb begin
        in_host   = (cur_mode == MW'(MODE_HOST));
        rd_req_h  = host_rd_req && in_host;
        wr_req_h  = host_wr_req && in_host;
        flush_act = host_flush && rd_ready;
    end

    pf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (mem_rdata),
        .pop   (pop),
        .clr   (flush_act),
        .rdata (fifo_rdata),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    pf_rdport #(.DW(DW)) u_rdport (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_req     (rd_req_h),
        .flush_act  (flush_act),
        .fifo_empty (fifo_empty),
        .fifo_rdata (fifo_rdata),
        .pop        (pop),
        .fill_need  (fill_need),
        .pend       (pend),
        .rd_valid   (host_rd_valid),
        .rd_data    (host_rd_data)
    );

    pf_seq #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_req     (wr_req_h),
        .wr_data    (host_wr_data),
        .fill_need  (fill_need),
        .fifo_empty (fifo_empty),
        .mem_ack    (mem_ack),
        .mem_addr   (mem_addr),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .push       (push),
        .step       (step),
        .rd_ready   (rd_ready),
        .wr_ready   (wr_ready),
        .wr_err     (wr_err)
    );

    pf_regs #(.AW(AW), .MW(MW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_ld    (host_addr_ld),
        .addr_in    (host_addr),
        .mode_ld    (host_mode_ld),
        .mode_in    (host_mode),
        .both_ready (rd_ready && wr_ready),
        .step       (step),
        .cur_addr   (cur_addr),
        .cur_mode   (cur_mode)
    );

    assign mem_addr = cur_addr;

    AST_FILL_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) && !mem_we |-> fifo_empty && !fifo_full);  // R2
    AST_NO_CMD_OFF_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_host && !mem_req && !pend) |=> !mem_req);  // R10

endmodule

// File: tb/dram_prefetch_ctrl_tb.sv
// Directed bench for dram_prefetch_ctrl with a behavioural DRAM model.
module dram_prefetch_ctrl_tb;
    localparam int DW = 32;
    localparam int AW = 20;
    localparam int MW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_rd_req = 1'b0;
    logic          host_rd_valid;
    logic [DW-1:0] host_rd_data;
    logic          host_wr_req = 1'b0;
    logic [DW-1:0] host_wr_data = '0;
    logic          host_flush = 1'b0;
    logic          host_addr_ld = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic          host_mode_ld = 1'b0;
    logic [MW-1:0] host_mode = '0;
    logic          rd_ready, wr_ready, wr_err;
    logic [AW-1:0] cur_addr;
    logic [MW-1:0] cur_mode;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    int lat = 0;
    int lat_cnt = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int vld_cnt = 0;
    logic [AW-1:0] rd_log [64];
    logic [AW-1:0] wr_addr_log;
    logic [DW-1:0] wr_data_log;

    always #5 clk = ~clk;

    dram_prefetch_ctrl #(.DW(DW), .AW(AW), .MW(MW), .DEPTH(16)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_rd_req(host_rd_req), .host_rd_valid(host_rd_valid), .host_rd_data(host_rd_data),
        .host_wr_req(host_wr_req), .host_wr_data(host_wr_data), .host_flush(host_flush),
        .host_addr_ld(host_addr_ld), .host_addr(host_addr),
        .host_mode_ld(host_mode_ld), .host_mode(host_mode),
        .rd_ready(rd_ready), .wr_ready(wr_ready), .wr_err(wr_err),
        .cur_addr(cur_addr), .cur_mode(cur_mode),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
        return 32'hC300_0000 | {12'h000, a};
    endfunction

    // DRAM model and monitor: acts on falling edges, logs every acknowledged command.
    initial begin
        forever begin
            @(negedge clk);
            if (host_rd_valid) vld_cnt++;
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (lat_cnt >= lat) begin
                    lat_cnt = 0;
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        wr_cnt++;
                        wr_addr_log = mem_addr;
                        wr_data_log = mem_wdata;
                    end else begin
                        if (rd_cnt < 64) rd_log[rd_cnt] = mem_addr;
                        rd_cnt++;
                        mem_rdata = word_at(mem_addr);
                    end
                end else begin
                    lat_cnt++;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        host_rd_req = 0; host_wr_req = 0; host_flush = 0;
        host_addr_ld = 0; host_mode_ld = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        lat = 0; lat_cnt = 0; rd_cnt = 0; wr_cnt = 0; vld_cnt = 0;
        @(negedge clk);
    endtask

    task automatic load_addr(input logic [AW-1:0] a);
        host_addr = a; host_addr_ld = 1'b1;
        @(negedge clk);
        host_addr_ld = 1'b0;
    endtask

    // One pop: pulse the request, wait for valid, compare data.
    task automatic pop_word(input string tag, input logic [DW-1:0] exp);
        bit got;
        got = 0;
        host_rd_req = 1'b1;
        @(negedge clk);
        host_rd_req = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (host_rd_valid) begin
                got = 1;
                break;
            end
            @(negedge clk);
        end
        chk({tag, " valid"}, got, 1);
        chk({tag, " data"}, host_rd_data, exp);
        @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 300; i++) begin
            if (rd_ready && wr_ready && !mem_req) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 rd_ready", rd_ready, 1);
        chk("R1 wr_ready", wr_ready, 1);
        chk("R1 wr_err", wr_err, 0);
        chk("R1 cur_addr", cur_addr, 0);
        chk("R1 cur_mode", cur_mode, 0);
        chk("R1 mem_req", mem_req, 0);
        chk("R1 rd_valid", host_rd_valid, 0);
    endtask

    // Fill and drain with pops overlapping pushes; then a 17th read refills.
    task automatic t_fill_drain();
        logic [AW-1:0] base;
        do_reset();
        base = 20'h00200;
        load_addr(base);
        chk("R9 addr load", cur_addr, base);
        host_rd_req = 1'b1;
        @(negedge clk);
        host_rd_req = 1'b0;
        chk("R3 rd_ready low in fill", rd_ready, 0);
        chk("R3 wr_ready high in fill", wr_ready, 1);
        for (int i = 0; i < 200; i++) begin
            if (host_rd_valid) break;
            @(negedge clk);
        end
        chk("R4 first word", host_rd_data, word_at(base));
        @(negedge clk);
        for (int k = 1; k < 16; k++) pop_word("R4 ordered pop", word_at(base + AW'(k)));
        wait_idle();
        chk("R2 read count", rd_cnt, 16);
        chk("R2 first addr", rd_log[0], base);
        chk("R2 last addr", rd_log[15], base + 20'd15);
        chk("R2 addr after fill", cur_addr, base + 20'd16);
        chk("R4 valid count", vld_cnt, 16);
        pop_word("R2 refill word", word_at(base + 20'd16));
        wait_idle();
        chk("R2 second burst count", rd_cnt, 32);
        chk("R2 second burst base", rd_log[16], base + 20'd16);
    endtask

    // Reads served from a filled FIFO issue no DRAM traffic.
    task automatic t_from_fifo();
        do_reset();
        lat = 2;
        pop_word("R4 stall on empty", word_at(0));
        wait_idle();
        for (int k = 1; k < 4; k++) pop_word("R5 buffered pop", word_at(AW'(k)));
        repeat (4) @(negedge clk);
        chk("R5 no extra reads", rd_cnt, 16);
    endtask

    task automatic t_write_ok();
        do_reset();
        lat = 3;
        load_addr(20'h00100);
        host_wr_data = 32'hDEAD_BEEF; host_wr_req = 1'b1;
        @(negedge clk);
        host_wr_req = 1'b0;
        chk("R3 wr_ready low in write", wr_ready, 0);
        chk("R6 mem_we", mem_we, 1);
        wait_idle();
        chk("R6 write count", wr_cnt, 1);
        chk("R6 write addr", wr_addr_log, 20'h00100);
        chk("R6 write data", wr_data_log, 32'hDEAD_BEEF);
        chk("R6 addr advanced", cur_addr, 20'h00101);
        chk("R6 no error", wr_err, 0);
    endtask

    task automatic t_write_reject();
        do_reset();
        lat = 1;
        host_rd_req = 1'b1;
        @(negedge clk);
        host_rd_req = 1'b0;
        repeat (3) @(negedge clk);
        host_wr_req = 1'b1;
        @(negedge clk);
        host_wr_req = 1'b0;
        chk("R7 refused during fill", wr_err, 1);
        wait_idle();
        do_reset();
        pop_word("R7 setup", word_at(0));
        wait_idle();
        host_wr_req = 1'b1; host_flush = 1'b1;
        @(negedge clk);
        host_wr_req = 1'b0; host_flush = 1'b0;
        chk("R7 refused with buffered data", wr_err, 1);
        repeat (4) @(negedge clk);
        chk("R7 no DRAM write", wr_cnt, 0);
        chk("R7 error sticky", wr_err, 1);
    endtask

    // Same-cycle read and write on an empty FIFO: read wins, write refused.
    task automatic t_collide();
        do_reset();
        host_rd_req = 1'b1; host_wr_req = 1'b1; host_wr_data = 32'h1234_5678;
        @(negedge clk);
        host_rd_req = 1'b0; host_wr_req = 1'b0;
        chk("R7 collision error", wr_err, 1);
        for (int i = 0; i < 200; i++) begin
            if (host_rd_valid) break;
            @(negedge clk);
        end
        chk("R7 collision read data", host_rd_data, word_at(0));
        wait_idle();
        chk("R7 collision no write", wr_cnt, 0);
    endtask

    task automatic t_flush();
        do_reset();
        pop_word("R8 setup", word_at(0));
        wait_idle();
        pop_word("R8 pre-flush pop", word_at(1));
        host_flush = 1'b1;
        @(negedge clk);
        host_flush = 1'b0;
        pop_word("R8 refill after flush", word_at(20'd16));
        wait_idle();
        chk("R8 refill count", rd_cnt, 32);
        host_flush = 1'b1; host_rd_req = 1'b1;
        @(negedge clk);
        host_flush = 1'b0; host_rd_req = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (host_rd_valid) break;
            @(negedge clk);
        end
        chk("R8 flush+read refills", host_rd_data, word_at(20'd32));
        wait_idle();
        do_reset();
        lat = 2;
        host_rd_req = 1'b1;
        @(negedge clk);
        host_rd_req = 1'b0;
        repeat (12) @(negedge clk);
        host_flush = 1'b1;
        @(negedge clk);
        host_flush = 1'b0;
        wait_idle();
        for (int k = 1; k < 3; k++) pop_word("R8 flush in fill ignored", word_at(AW'(k)));
    endtask

    task automatic t_load_gate();
        do_reset();
        lat = 2;
        host_rd_req = 1'b1;
        @(negedge clk);
        host_rd_req = 1'b0;
        repeat (2) @(negedge clk);
        host_addr = 20'h0ABCD; host_addr_ld = 1'b1;
        host_mode = 2'd3; host_mode_ld = 1'b1;
        @(negedge clk);
        host_addr_ld = 1'b0; host_mode_ld = 1'b0;
        wait_idle();
        chk("R9 addr load ignored", cur_addr, 20'd16);
        chk("R9 mode load ignored", cur_mode, 0);
    endtask

    task automatic t_mode();
        do_reset();
        host_mode = 2'd1; host_mode_ld = 1'b1;
        @(negedge clk);
        host_mode_ld = 1'b0;
        chk("R9 mode loaded", cur_mode, 1);
        host_rd_req = 1'b1;
        @(negedge clk);
        host_rd_req = 1'b0;
        host_wr_req = 1'b1;
        @(negedge clk);
        host_wr_req = 1'b0;
        repeat (20) @(negedge clk);
        chk("R10 no reads", rd_cnt, 0);
        chk("R10 no writes", wr_cnt, 0);
        chk("R10 no valid", vld_cnt, 0);
        chk("R10 no error", wr_err, 0);
    endtask

    task automatic t_wr_then_rd();
        do_reset();
        lat = 3;
        load_addr(20'h00040);
        host_wr_data = 32'h0F0F_0F0F; host_wr_req = 1'b1;
        @(negedge clk);
        host_wr_req = 1'b0;
        host_rd_req = 1'b1;
        @(negedge clk);
        host_rd_req = 1'b0;
        chk("R11 write still outstanding", wr_ready, 0);
        for (int i = 0; i < 200; i++) begin
            if (host_rd_valid) break;
            @(negedge clk);
        end
        chk("R11 held read data", host_rd_data, word_at(20'h00041));
        wait_idle();
        chk("R11 write addr", wr_addr_log, 20'h00040);
        chk("R11 fill base", rd_log[0], 20'h00041);
        chk("R11 fill count", rd_cnt, 16);
        chk("R11 no error", wr_err, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_fill_drain();
        t_from_fifo();
        t_write_ok();
        t_write_reject();
        t_collide();
        t_flush();
        t_load_gate();
        t_mode();
        t_wr_then_rd();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule